// File: doc/BRIEF.md
# I2C status and interrupt flag logic

This block keeps the status bits of an I2C controller and folds the event pulses of the bus engine into a single interrupt-pending flag. The bus engine reports these events as one-cycle pulses: end of the eight data bits, end of the ACK bit, a received calling address, other address matches, lost arbitration, SMBus timeouts and a detected stop condition. Software reaches the block through write strobes for the status register, control register 1 and the glitch-filter register. The block decodes only the bit that each strobe acts on.

The block sets the flags one clock after an event. It clears them with write-one-to-clear and lets a set beat a clear that lands in the same cycle. A sticky stop flag keeps the interrupt asserted until it is cleared. The interrupt output is the pending flag gated by the interrupt enable.

Top module: `i2c_stat_irq`

## Requirements
- R1: A status write with `stat_if_wdata_i`=1 clears `irq_flag_o` at the next edge. A status write with `stat_if_wdata_i`=0 leaves it unchanged.
- R2: With `fast_ack_i`=0, `ack_done_i` sets `irq_flag_o` and `byte_done_i` does not. With `fast_ack_i`=1 the roles swap.
- R3: `irq_flag_o` also sets on `alt_match_i`, on `arb_lost_i`, on a primary or range slave hit (R6) and on `tmo_i[0]` (SCL-low timeout). `tmo_i[1]` (SCL-high) and `tmo_i[2]` (SDA-high) do not set it.
- R4: `stop_det_i` always sets `stop_flag_o`. It sets `irq_flag_o` only when `stop_ie_i`=1. A glitch-filter write with `flt_stopf_wdata_i`=1 clears `stop_flag_o`.
- R5: While `stop_flag_o`=1 and `stop_ie_i`=1, `irq_flag_o` is set again on every edge, so a clear attempt on it does not hold. The stop flag must be cleared first.
- R6: `addressed_o` sets when `addr_recv_i` pulses and either of two conditions holds. The first is that `call_addr_i` is nonzero and equals `own_addr_i`. The second is that `range_en_i`=1 and `own_addr_i` < `call_addr_i` <= `range_addr_i`, compared unsigned.
- R7: Any `ctrl_wr_i` pulse clears `addressed_o`.
- R8: On a slave hit, `slave_tx_o` takes `call_rw_i`. A value of 0 means the slave receives and a value of 1 means the slave transmits. Otherwise `slave_tx_o` holds.
- R9: On `ack_done_i`, `nack_o` takes `ack_level_i`. A value of 0 means an ACK was seen and a value of 1 means no acknowledge. Otherwise `nack_o` holds.
- R10: `irq_o` equals `irq_flag_o` AND `irq_en_i`, combinationally.
- R11: A set event and a clear write in the same cycle leave the flag set.
- R12: Reset drives every status output to 0. Flags change one edge after the pulse that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_ack_i | input | 1 | Fast-ACK mode |
| irq_en_i | input | 1 | Interrupt enable from control register 1 |
| stop_ie_i | input | 1 | Stop interrupt enable from glitch-filter register |
| byte_done_i | input | 1 | Eight data bits done |
| ack_done_i | input | 1 | ACK bit done |
| addr_recv_i | input | 1 | Calling address received |
| call_addr_i | input | ADDR_W | Calling address |
| call_rw_i | input | 1 | R/W bit of calling address |
| own_addr_i | input | ADDR_W | Primary slave address, range lower bound |
| range_addr_i | input | ADDR_W | Range upper bound |
| range_en_i | input | 1 | Range matching enable |
| alt_match_i | input | 1 | Alert, second or general-call match |
| arb_lost_i | input | 1 | Arbitration lost |
| tmo_i | input | TMO_N | SMBus timeouts: 0 SCL low, 1 SCL high, 2 SDA high |
| stop_det_i | input | 1 | Stop condition detected |
| ack_level_i | input | 1 | Received ACK level |
| ctrl_wr_i | input | 1 | Control register 1 write strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_if_wdata_i | input | 1 | Write data for interrupt flag bit |
| flt_wr_i | input | 1 | Glitch-filter register write strobe |
| flt_stopf_wdata_i | input | 1 | Write data for stop flag bit |
| addressed_o | output | 1 | Addressed as slave |
| slave_tx_o | output | 1 | Slave read/write direction |
| irq_flag_o | output | 1 | Interrupt pending |
| nack_o | output | 1 | Receive acknowledge status |
| stop_flag_o | output | 1 | Sticky stop flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Every flag and captured bit is due exactly one rising edge after the pulse or strobe that moves it. `irq_o` follows the flag and the enable in the same cycle with no register between them. The bench changes inputs only on falling edges and advances its expected state at the rising edge. It compares all six outputs at the following falling edge, where the registered results have settled and the inputs are still those that produced them.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_IF    = 0;
  localparam int unsigned FLG_STOPF = 1;
  localparam int unsigned FLG_AAS   = 2;
  localparam int unsigned TMO_SCL_LO = 0;
  localparam int unsigned TMO_SCL_HI = 1;
  localparam int unsigned TMO_SDA_HI = 2;
endpackage

// File: rtl/i2c_slave_hit.sv
module i2c_slave_hit #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              addr_recv_i,
  input  logic [ADDR_W-1:0] call_addr_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] range_addr_i,
  input  logic              range_en_i,
  output logic              hit_o
);
  logic prim_hit, rng_hit;

  always_comb begin
    prim_hit = (call_addr_i != '0) && (call_addr_i == own_addr_i);
    // range excludes lower bound, includes upper
    rng_hit  = range_en_i && (call_addr_i > own_addr_i) && (call_addr_i <= range_addr_i);
    hit_o    = addr_recv_i && (prim_hit || rng_hit);
  end
endmodule

// File: rtl/i2c_irq_src.sv
module i2c_irq_src #(
  parameter int unsigned     TMO_N        = 3,
  parameter logic [TMO_N-1:0] TMO_IRQ_MASK = 3'b001
) (
  input  logic             fast_ack_i,
  input  logic             byte_done_i,
  input  logic             ack_done_i,
  input  logic             slave_hit_i,
  input  logic             alt_match_i,
  input  logic             arb_lost_i,
  input  logic [TMO_N-1:0] tmo_i,
  input  logic             stop_det_i,
  input  logic             stop_ie_i,
  input  logic             stop_flag_i,
  output logic             set_o
);
  logic xfer_end, tmo_hit, stop_term;

  always_comb begin
    xfer_end  = fast_ack_i ? byte_done_i : ack_done_i;
    tmo_hit   = |(tmo_i & TMO_IRQ_MASK);
    // pending stop flag keeps re-arming the interrupt
    stop_term = stop_ie_i && (stop_det_i || stop_flag_i);
    set_o     = xfer_end | slave_hit_i | alt_match_i | arb_lost_i | tmo_hit | stop_term;
  end
endmodule

// File: rtl/i2c_sticky_bit.sv
module i2c_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_cap_bit.sv
module i2c_cap_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
#(
  parameter int unsigned      ADDR_W       = 7,
  parameter int unsigned      TMO_N        = 3,
  parameter logic [TMO_N-1:0] TMO_IRQ_MASK = 3'b001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_ack_i,
  input  logic              irq_en_i,
  input  logic              stop_ie_i,
  input  logic              byte_done_i,
  input  logic              ack_done_i,
  input  logic              addr_recv_i,
  input  logic [ADDR_W-1:0] call_addr_i,
  input  logic              call_rw_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] range_addr_i,
  input  logic              range_en_i,
  input  logic              alt_match_i,
  input  logic              arb_lost_i,
  input  logic [TMO_N-1:0]  tmo_i,
  input  logic              stop_det_i,
  input  logic              ack_level_i,
  input  logic              ctrl_wr_i,
  input  logic              stat_wr_i,
  input  logic              stat_if_wdata_i,
  input  logic              flt_wr_i,
  input  logic              flt_stopf_wdata_i,
  output logic              addressed_o,
  output logic              slave_tx_o,
  output logic              irq_flag_o,
  output logic              nack_o,
  output logic              stop_flag_o,
  output logic              irq_o
);
  logic                 slave_hit, if_set;
  logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_q;

  i2c_slave_hit #(.ADDR_W(ADDR_W)) u_hit (
    .addr_recv_i (addr_recv_i),
    .call_addr_i (call_addr_i),
    .own_addr_i  (own_addr_i),
    .range_addr_i(range_addr_i),
    .range_en_i  (range_en_i),
    .hit_o       (slave_hit)
  );

  i2c_irq_src #(.TMO_N(TMO_N), .TMO_IRQ_MASK(TMO_IRQ_MASK)) u_src (
    .fast_ack_i (fast_ack_i),
    .byte_done_i(byte_done_i),
    .ack_done_i (ack_done_i),
    .slave_hit_i(slave_hit),
    .alt_match_i(alt_match_i),
    .arb_lost_i (arb_lost_i),
    .tmo_i      (tmo_i),
    .stop_det_i (stop_det_i),
    .stop_ie_i  (stop_ie_i),
    .stop_flag_i(fl_q[FLG_STOPF]),
    .set_o      (if_set)
  );

  always_comb begin
    fl_set[FLG_IF]    = if_set;
    fl_clr[FLG_IF]    = stat_wr_i & stat_if_wdata_i;
    fl_set[FLG_STOPF] = stop_det_i;
    fl_clr[FLG_STOPF] = flt_wr_i & flt_stopf_wdata_i;
    fl_set[FLG_AAS]   = slave_hit;
    fl_clr[FLG_AAS]   = ctrl_wr_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    i2c_sticky_bit u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (fl_set[g]),
      .clr_i (fl_clr[g]),
      .q_o   (fl_q[g])
    );
  end

  i2c_cap_bit u_srw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (slave_hit),
    .d_i   (call_rw_i),
    .q_o   (slave_tx_o)
  );

  i2c_cap_bit u_rxak (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ack_done_i),
    .d_i   (ack_level_i),
    .q_o   (nack_o)
  );

  assign irq_flag_o  = fl_q[FLG_IF];
  assign stop_flag_o = fl_q[FLG_STOPF];
  assign addressed_o = fl_q[FLG_AAS];
  assign irq_o       = fl_q[FLG_IF] & irq_en_i;
endmodule

// File: rtl/i2c_stat_irq_chk.sv
module i2c_stat_irq_chk #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fast_ack_i,
  input logic              irq_en_i,
  input logic              stop_ie_i,
  input logic              byte_done_i,
  input logic              ack_done_i,
  input logic              addr_recv_i,
  input logic [ADDR_W-1:0] call_addr_i,
  input logic              call_rw_i,
  input logic [ADDR_W-1:0] own_addr_i,
  input logic [ADDR_W-1:0] range_addr_i,
  input logic              range_en_i,
  input logic              arb_lost_i,
  input logic              stop_det_i,
  input logic              ack_level_i,
  input logic              ctrl_wr_i,
  input logic              stat_wr_i,
  input logic              stat_if_wdata_i,
  input logic              addressed_o,
  input logic              slave_tx_o,
  input logic              irq_flag_o,
  input logic              nack_o,
  input logic              stop_flag_o,
  input logic              irq_o
);
  assert_w0_keeps_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && !stat_if_wdata_i && irq_flag_o |=> irq_flag_o);

  assert_fack_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_ack_i && byte_done_i |=> irq_flag_o);

  assert_arb_lost_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i |=> irq_flag_o);

  assert_stop_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> stop_flag_o);

  assert_stop_rearm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_flag_o && stop_ie_i |=> irq_flag_o);

  assert_range_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_recv_i && range_en_i && (call_addr_i > own_addr_i) && (call_addr_i <= range_addr_i)
    |=> addressed_o);

  assert_ctrl_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && !addr_recv_i |=> !addressed_o);

  assert_srw_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_recv_i && (call_addr_i != '0) && (call_addr_i == own_addr_i)
    |=> slave_tx_o == $past(call_rw_i));

  assert_rxak_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_done_i |=> nack_o == $past(ack_level_i));

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i && stat_wr_i && stat_if_wdata_i |=> irq_flag_o);
endmodule

bind i2c_stat_irq i2c_stat_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fast_ack_i     (fast_ack_i),
  .irq_en_i       (irq_en_i),
  .stop_ie_i      (stop_ie_i),
  .byte_done_i    (byte_done_i),
  .ack_done_i     (ack_done_i),
  .addr_recv_i    (addr_recv_i),
  .call_addr_i    (call_addr_i),
  .call_rw_i      (call_rw_i),
  .own_addr_i     (own_addr_i),
  .range_addr_i   (range_addr_i),
  .range_en_i     (range_en_i),
  .arb_lost_i     (arb_lost_i),
  .stop_det_i     (stop_det_i),
  .ack_level_i    (ack_level_i),
  .ctrl_wr_i      (ctrl_wr_i),
  .stat_wr_i      (stat_wr_i),
  .stat_if_wdata_i(stat_if_wdata_i),
  .addressed_o    (addressed_o),
  .slave_tx_o     (slave_tx_o),
  .irq_flag_o     (irq_flag_o),
  .nack_o         (nack_o),
  .stop_flag_o    (stop_flag_o),
  .irq_o          (irq_o)
);

// File: tb/test_i2c_stat_irq.sv
`timescale 1ns/1ps
module test_i2c_stat_irq;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned TMO_N  = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fast_ack, irq_en, stop_ie, byte_done, ack_done, addr_recv, call_rw;
  logic [ADDR_W-1:0] call_addr, own_addr, range_addr;
  logic range_en, alt_match, arb_lost, stop_det, ack_level;
  logic [TMO_N-1:0] tmo;
  logic ctrl_wr, stat_wr, stat_if_wd, flt_wr, flt_stopf_wd;
  logic addressed, slave_tx, irq_flag, nack, stop_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  logic m_if, m_stopf, m_aas, m_srw, m_rxak;

  always #4 clk = ~clk;

  i2c_stat_irq i_i2c_stat_irq (
    .clk_i(clk), .rst_ni(rst_ni), .fast_ack_i(fast_ack), .irq_en_i(irq_en),
    .stop_ie_i(stop_ie), .byte_done_i(byte_done), .ack_done_i(ack_done),
    .addr_recv_i(addr_recv), .call_addr_i(call_addr), .call_rw_i(call_rw),
    .own_addr_i(own_addr), .range_addr_i(range_addr), .range_en_i(range_en),
    .alt_match_i(alt_match), .arb_lost_i(arb_lost), .tmo_i(tmo),
    .stop_det_i(stop_det), .ack_level_i(ack_level), .ctrl_wr_i(ctrl_wr),
    .stat_wr_i(stat_wr), .stat_if_wdata_i(stat_if_wd), .flt_wr_i(flt_wr),
    .flt_stopf_wdata_i(flt_stopf_wd), .addressed_o(addressed), .slave_tx_o(slave_tx),
    .irq_flag_o(irq_flag), .nack_o(nack), .stop_flag_o(stop_flag), .irq_o(irq)
  );

  function automatic logic exp_hit();
    logic prim, rng;
    prim = (call_addr != '0) && (call_addr == own_addr);
    rng  = range_en && (call_addr > own_addr) && (call_addr <= range_addr);
    return addr_recv && (prim || rng);
  endfunction

  function automatic logic exp_if_set();
    logic xfer;
    xfer = fast_ack ? byte_done : ack_done;
    return xfer | exp_hit() | alt_match | arb_lost | tmo[0] |
           (stop_ie & (stop_det | m_stopf));
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R6 R7 addressed", addressed, m_aas);
    check("R8 slave_tx", slave_tx, m_srw);
    check("R1 R2 R3 R5 R11 irq_flag", irq_flag, m_if);
    check("R9 nack", nack, m_rxak);
    check("R4 stop_flag", stop_flag, m_stopf);
    check("R10 irq", irq, m_if & irq_en);
  endtask

  task automatic idle();
    byte_done = 0; ack_done = 0; addr_recv = 0; alt_match = 0; arb_lost = 0;
    tmo = '0; stop_det = 0; ctrl_wr = 0; stat_wr = 0; stat_if_wd = 0;
    flt_wr = 0; flt_stopf_wd = 0;
  endtask

  task automatic cyc();
    logic hit, s;
    @(posedge clk);
    hit = exp_hit();
    s   = exp_if_set();
    m_if    = s | (m_if & !(stat_wr & stat_if_wd));
    m_stopf = stop_det | (m_stopf & !(flt_wr & flt_stopf_wd));
    m_aas   = hit | (m_aas & !ctrl_wr);
    if (hit) m_srw = call_rw;
    if (ack_done) m_rxak = ack_level;
    @(negedge clk);
    check_all();
    idle();
  endtask

  task automatic clr_if();  stat_wr = 1; stat_if_wd = 1; cyc(); endtask
  task automatic clr_stop(); flt_wr = 1; flt_stopf_wd = 1; cyc(); endtask

  task automatic addr_try(input int a, input logic rw);
    addr_recv = 1; call_addr = ADDR_W'(a); call_rw = rw; cyc();
    ctrl_wr = 1; cyc();
    clr_if();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_if = 0; m_stopf = 0; m_aas = 0; m_srw = 0; m_rxak = 0;
    fast_ack = 0; irq_en = 1; stop_ie = 0; call_addr = '0; call_rw = 0;
    own_addr = '0; range_addr = '0; range_en = 0; ack_level = 0;
    idle();
    repeat (3) @(negedge clk);
    check_all(); // R12 reset state
    rst_ni = 1;
    @(negedge clk);
    check_all();

    // R2 normal mode: byte end alone does not set, ACK end does
    byte_done = 1; cyc();
    ack_done = 1; ack_level = 1; cyc();          // R9 nack=1
    stat_wr = 1; stat_if_wd = 0; cyc();           // R1 write 0 keeps
    clr_if();
    // R2 fast-ACK mode
    fast_ack = 1;
    ack_done = 1; ack_level = 0; cyc();
    byte_done = 1; cyc();
    clr_if();
    fast_ack = 0;
    // R3 timeouts
    tmo = 3'b110; cyc();
    tmo = 3'b001; cyc();
    clr_if();
    alt_match = 1; cyc(); clr_if();
    // R4 stop without interrupt enable
    stop_det = 1; cyc();
    clr_stop();
    // R5 stop with enable: clear ordering
    stop_ie = 1;
    stop_det = 1; cyc();
    clr_if();                                     // does not hold
    clr_stop();
    clr_if();                                     // now clears
    stop_ie = 0;
    // R6 range boundaries
    own_addr = 7'd10; range_addr = 7'd20; range_en = 1;
    addr_try(10, 1);
    addr_try(11, 0);
    addr_try(20, 1);
    addr_try(21, 1);
    addr_try(9, 1);
    range_en = 0;
    addr_try(15, 1);
    own_addr = '0;
    addr_try(0, 1);                               // zero address never a primary hit
    // R11 set beats clear, R7 hit beats ctrl write
    arb_lost = 1; stat_wr = 1; stat_if_wd = 1; cyc();
    own_addr = 7'd33;
    addr_recv = 1; call_addr = 7'd33; call_rw = 1; ctrl_wr = 1; cyc();
    ctrl_wr = 1; cyc();
    // R10 gating
    irq_en = 0; cyc();
    irq_en = 1; cyc();
    clr_if();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      fast_ack   = ($urandom_range(0, 7) == 0) ? ~fast_ack : fast_ack;
      irq_en     = ($urandom_range(0, 7) != 0);
      stop_ie    = ($urandom_range(0, 1) == 1);
      range_en   = ($urandom_range(0, 1) == 1);
      own_addr   = ADDR_W'($urandom_range(0, 12));
      range_addr = ADDR_W'($urandom_range(0, 15));
      call_addr  = ADDR_W'($urandom_range(0, 15));
      call_rw    = 1'($urandom_range(0, 1));
      ack_level  = 1'($urandom_range(0, 1));
      byte_done  = ($urandom_range(0, 5) == 0);
      ack_done   = ($urandom_range(0, 5) == 0);
      addr_recv  = ($urandom_range(0, 4) == 0);
      alt_match  = ($urandom_range(0, 15) == 0);
      arb_lost   = ($urandom_range(0, 15) == 0);
      tmo        = ($urandom_range(0, 5) == 0) ? TMO_N'($urandom_range(0, 7)) : '0;
      stop_det   = ($urandom_range(0, 11) == 0);
      ctrl_wr    = ($urandom_range(0, 5) == 0);
      stat_wr    = ($urandom_range(0, 2) == 0);
      stat_if_wd = 1'($urandom_range(0, 1));
      flt_wr     = ($urandom_range(0, 3) == 0);
      flt_stopf_wd = 1'($urandom_range(0, 1));
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule